// File: doc/BRIEF.md
# Bitsliced Substitution Unit for a Four-Word Cipher State

This block substitutes a 128-bit cipher state that is held as four 32-bit words. Bit position i of the four words forms one 4-bit value (a nibble). The selected 4-to-4 substitution box replaces every such nibble, and all word positions are handled in parallel. Eight forward boxes are available, along with the inverse of each. A round controller picks the box with a 3-bit index and the direction with a single flag. In the forward direction, round r normally uses box r mod 8. In the inverse direction the boxes run 7, 6, ... 0 and then repeat. Key mixing, the linear layer and round sequencing belong to the surrounding datapath.

The unit has no registers. The substitution is not a per-nibble table lookup. It is a word-wide network of AND, OR and NOT operations: one set of sixteen minterm words is decoded from the four input words, and then ORed into the four output words according to the selected box. Complemented words are made by XOR with an all-ones word that the unit builds internally. The results always leave in canonical word order, so the caller needs no per-box renaming.

Top module: `sbx_bitslice_unit`

## Requirements
- R1: Bit i of input word k is bit k of the nibble at position i, with word 0 as the least significant bit. Bit i of output word k is bit k of that position's substituted nibble.
- R2: With inverse_i low, box 0 maps nibbles 0..15 to 3 8 15 1 10 6 5 11 14 13 4 2 7 0 9 12. Box 1 maps them to 15 12 2 7 9 0 5 10 1 11 14 8 6 13 3 4. Box 2 maps them to 8 6 7 9 3 12 10 15 13 1 14 4 0 11 5 2. Box 3 maps them to 0 15 11 8 12 9 6 3 13 1 2 4 10 7 5 14.
- R3: With inverse_i low, box 4 maps nibbles 0..15 to 1 15 8 3 12 0 11 6 2 5 4 10 9 14 7 13. Box 5 maps them to 15 5 2 11 4 10 9 12 0 3 14 8 13 6 7 1. Box 6 maps them to 7 2 12 5 8 4 6 11 14 9 1 15 13 3 10 0. Box 7 maps them to 1 13 15 0 14 8 2 11 7 4 12 10 9 3 5 6.
- R4: With inverse_i high, the unit applies the inverse of box box_i. For every box and all 16 nibble values, the inverse of the forward result gives back the original value.
- R5: Every bit position is substituted independently of the others. If each input word is all zeros or all ones, then each output word is all zeros or all ones.
- R6: box_i selects among all eight boxes, and the outputs are in canonical order (z0_o..z3_o) whichever box and direction is selected.
- R7: The unit is purely combinational. The outputs follow an input change without any clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| w0_i | input | WORD_W | State word 0 (nibble bit 0) |
| w1_i | input | WORD_W | State word 1 (nibble bit 1) |
| w2_i | input | WORD_W | State word 2 (nibble bit 2) |
| w3_i | input | WORD_W | State word 3 (nibble bit 3) |
| box_i | input | 3 | Substitution box index |
| inverse_i | input | 1 | 0 = forward box, 1 = inverse box |
| z0_o | output | WORD_W | Substituted word 0 |
| z1_o | output | WORD_W | Substituted word 1 |
| z2_o | output | WORD_W | Substituted word 2 |
| z3_o | output | WORD_W | Substituted word 3 |

## Verification
The bench drives a ramp pattern that places all sixteen nibble values at known positions, a reversed ramp, and a scrambled pattern. It checks every box in both directions against tables it holds itself. A swapped word order or a wrong bit weight would show up as nibbles that match the table for the wrong value. A uniform sweep feeds each of the sixteen constant nibbles to every box and direction. A design that leaked information between bit positions, or that got the complement constant wrong, would give mixed output words or wrong values there. Round trips through the forward box and then the inverse box reveal any inverse table that is not a true inverse. Changing box_i between clock edges shows whether the unit depends on a clock.

// File: rtl/sbx_pkg.sv
package sbx_pkg;

   localparam int unsigned NIB_BITS  = 4;
   localparam int unsigned NIB_VALS  = 1 << NIB_BITS;
   localparam int unsigned BOX_COUNT = 8;
   localparam int unsigned TBL_W     = NIB_VALS * NIB_BITS;

   // Forward box contents, entry 0 at the most significant end.
   function automatic logic [TBL_W-1:0] fwd_row(input logic [2:0] b);
      logic [TBL_W-1:0] r;
      case (b)
         3'd0: r = {4'd3, 4'd8, 4'd15,4'd1, 4'd10,4'd6, 4'd5, 4'd11,
                    4'd14,4'd13,4'd4, 4'd2, 4'd7, 4'd0, 4'd9, 4'd12};
         3'd1: r = {4'd15,4'd12,4'd2, 4'd7, 4'd9, 4'd0, 4'd5, 4'd10,
                    4'd1, 4'd11,4'd14,4'd8, 4'd6, 4'd13,4'd3, 4'd4};
         3'd2: r = {4'd8, 4'd6, 4'd7, 4'd9, 4'd3, 4'd12,4'd10,4'd15,
                    4'd13,4'd1, 4'd14,4'd4, 4'd0, 4'd11,4'd5, 4'd2};
         3'd3: r = {4'd0, 4'd15,4'd11,4'd8, 4'd12,4'd9, 4'd6, 4'd3,
                    4'd13,4'd1, 4'd2, 4'd4, 4'd10,4'd7, 4'd5, 4'd14};
         3'd4: r = {4'd1, 4'd15,4'd8, 4'd3, 4'd12,4'd0, 4'd11,4'd6,
                    4'd2, 4'd5, 4'd4, 4'd10,4'd9, 4'd14,4'd7, 4'd13};
         3'd5: r = {4'd15,4'd5, 4'd2, 4'd11,4'd4, 4'd10,4'd9, 4'd12,
                    4'd0, 4'd3, 4'd14,4'd8, 4'd13,4'd6, 4'd7, 4'd1};
         3'd6: r = {4'd7, 4'd2, 4'd12,4'd5, 4'd8, 4'd4, 4'd6, 4'd11,
                    4'd14,4'd9, 4'd1, 4'd15,4'd13,4'd3, 4'd10,4'd0};
         default: r = {4'd1, 4'd13,4'd15,4'd0, 4'd14,4'd8, 4'd2, 4'd11,
                       4'd7, 4'd4, 4'd12,4'd10,4'd9, 4'd3, 4'd5, 4'd6};
      endcase
      return r;
   endfunction

   function automatic logic [NIB_BITS-1:0] fwd_nib(input logic [2:0] b,
                                                   input logic [NIB_BITS-1:0] v);
      logic [TBL_W-1:0] r;
      r = fwd_row(b);
      return r[(NIB_VALS-1-int'(v))*NIB_BITS +: NIB_BITS];
   endfunction

   // Inverse found by search over the forward box.
   function automatic logic [NIB_BITS-1:0] box_nib(input logic [2:0] b,
                                                   input logic inv,
                                                   input logic [NIB_BITS-1:0] v);
      logic [NIB_BITS-1:0] res;
      res = fwd_nib(b, v);
      if (inv) begin
         res = '0;
         for (int u = 0; u < int'(NIB_VALS); u++) begin
            if (fwd_nib(b, NIB_BITS'(u)) == v) res = NIB_BITS'(u);
         end
      end
      return res;
   endfunction

   // Plane table: entry v at bits [4v +: 4].
   function automatic logic [TBL_W-1:0] plane_table(input logic [2:0] b,
                                                    input logic inv);
      logic [TBL_W-1:0] t;
      for (int v = 0; v < int'(NIB_VALS); v++)
         t[v*NIB_BITS +: NIB_BITS] = box_nib(b, inv, NIB_BITS'(v));
      return t;
   endfunction

endpackage

// File: rtl/sbx_minterm_gen.sv
module sbx_minterm_gen #(
   parameter int unsigned WORD_W = 32
) (
   input  logic [sbx_pkg::NIB_BITS-1:0][WORD_W-1:0] w_i,
   output logic [sbx_pkg::NIB_VALS-1:0][WORD_W-1:0] mt_o
);
   import sbx_pkg::*;

   localparam logic [WORD_W-1:0] ALL_ONES = {WORD_W{1'b1}};

   logic [NIB_BITS-1:0][WORD_W-1:0] wn;

   generate
      for (genvar k = 0; k < int'(NIB_BITS); k++) begin : g_cmp
         assign wn[k] = w_i[k] ^ ALL_ONES;
      end
   endgenerate

   always_comb begin
      logic [WORD_W-1:0]   acc;
      logic [NIB_VALS-1:0] col;
      for (int v = 0; v < int'(NIB_VALS); v++) begin
         acc = ALL_ONES;
         for (int k = 0; k < int'(NIB_BITS); k++)
            acc = acc & (v[k] ? w_i[k] : wn[k]);
         mt_o[v] = acc;
      end
      if (!$isunknown(w_i)) begin
         for (int i = 0; i < int'(WORD_W); i++) begin
            for (int v = 0; v < int'(NIB_VALS); v++) col[v] = mt_o[v][i];
            AST_MINTERM_ONEHOT: assert ($onehot(col)) else $error("minterm column not one-hot"); // R1
         end
      end
   end

endmodule

// File: rtl/sbx_plane.sv
module sbx_plane #(
   parameter int unsigned WORD_W = 32
) (
   input  logic [sbx_pkg::TBL_W-1:0]                table_i,
   input  logic [sbx_pkg::NIB_VALS-1:0][WORD_W-1:0] mt_i,
   output logic [sbx_pkg::NIB_BITS-1:0][WORD_W-1:0] y_o
);
   import sbx_pkg::*;

   always_comb begin
      logic [NIB_VALS-1:0] seen;
      y_o  = '0;
      seen = '0;
      for (int v = 0; v < int'(NIB_VALS); v++) begin
         for (int j = 0; j < int'(NIB_BITS); j++) begin
            if (table_i[v*NIB_BITS + j]) y_o[j] = y_o[j] | mt_i[v];
         end
         seen[table_i[v*NIB_BITS +: NIB_BITS]] = 1'b1;
      end
      if (!$isunknown(table_i)) begin
         AST_TABLE_BIJECTIVE: assert (&seen) else $error("plane table is not a permutation"); // R4
      end
   end

endmodule

// File: rtl/sbx_bitslice_unit.sv
module sbx_bitslice_unit #(
   parameter int unsigned WORD_W          = 32,
   parameter int unsigned PARALLEL_PLANES = 1
) (
   input  logic [WORD_W-1:0] w0_i,
   input  logic [WORD_W-1:0] w1_i,
   input  logic [WORD_W-1:0] w2_i,
   input  logic [WORD_W-1:0] w3_i,
   input  logic [2:0]        box_i,
   input  logic              inverse_i,
   output logic [WORD_W-1:0] z0_o,
   output logic [WORD_W-1:0] z1_o,
   output logic [WORD_W-1:0] z2_o,
   output logic [WORD_W-1:0] z3_o
);
   import sbx_pkg::*;

   localparam int unsigned PLANES = 2 * BOX_COUNT;
   localparam int unsigned TOP    = WORD_W - 1;

   generate
      if (WORD_W < 1) begin : g_bad_width
         $error("WORD_W must be at least 1");
      end
      if (PARALLEL_PLANES > 1) begin : g_bad_variant
         $error("PARALLEL_PLANES must be 0 or 1");
      end
   endgenerate

   logic [NIB_BITS-1:0][WORD_W-1:0] w_in;
   logic [NIB_VALS-1:0][WORD_W-1:0] mt;
   logic [NIB_BITS-1:0][WORD_W-1:0] y_sel;

   assign w_in = {w3_i, w2_i, w1_i, w0_i};

   sbx_minterm_gen #(.WORD_W(WORD_W)) i_mint (
      .w_i  (w_in),
      .mt_o (mt)
   );

   generate
      if (PARALLEL_PLANES == 1) begin : g_par
         logic [PLANES-1:0][NIB_BITS-1:0][WORD_W-1:0] res;
         for (genvar p = 0; p < int'(PLANES); p++) begin : g_plane
            localparam logic [TBL_W-1:0] TBL = plane_table(3'(p % 8), 1'(p / 8));
            sbx_plane #(.WORD_W(WORD_W)) i_plane (
               .table_i (TBL),
               .mt_i    (mt),
               .y_o     (res[p])
            );
         end
         assign y_sel = res[{inverse_i, box_i}];
      end else begin : g_ser
         logic [TBL_W-1:0] tbl_dyn;
         assign tbl_dyn = plane_table(box_i, inverse_i);
         sbx_plane #(.WORD_W(WORD_W)) i_plane (
            .table_i (tbl_dyn),
            .mt_i    (mt),
            .y_o     (y_sel)
         );
      end
   endgenerate

   assign z0_o = y_sel[0];
   assign z1_o = y_sel[1];
   assign z2_o = y_sel[2];
   assign z3_o = y_sel[3];

   always_comb begin
      logic [NIB_BITS-1:0] xl, zl, xh, zh;
      logic                uni_in, uni_out;
      xl = {w3_i[0], w2_i[0], w1_i[0], w0_i[0]};
      zl = {z3_o[0], z2_o[0], z1_o[0], z0_o[0]};
      xh = {w3_i[TOP], w2_i[TOP], w1_i[TOP], w0_i[TOP]};
      zh = {z3_o[TOP], z2_o[TOP], z1_o[TOP], z0_o[TOP]};
      uni_in  = (&w0_i || ~|w0_i) && (&w1_i || ~|w1_i) &&
                (&w2_i || ~|w2_i) && (&w3_i || ~|w3_i);
      uni_out = (&z0_o || ~|z0_o) && (&z1_o || ~|z1_o) &&
                (&z2_o || ~|z2_o) && (&z3_o || ~|z3_o);
      if (!$isunknown({w0_i, w1_i, w2_i, w3_i, box_i, inverse_i,
                       z0_o, z1_o, z2_o, z3_o})) begin
         AST_LOW_NIBBLE_MAP: assert (zl == box_nib(box_i, inverse_i, xl)) else $error("nibble map mismatch"); // R2, R3, R6
         if (inverse_i) begin
            AST_ROUND_TRIP: assert (fwd_nib(box_i, zh) == xh) else $error("inverse not undone by forward box"); // R4
         end
         AST_UNIFORM_WORDS: assert (!uni_in || uni_out) else $error("uniform input gave mixed output"); // R5
      end
   end

endmodule

// File: tb/test_sbx_bitslice_unit.sv
module test_sbx_bitslice_unit;

   localparam int W          = 32;
   localparam int CLK_PERIOD = 10;

   logic clk = 1'b0;
   always #(CLK_PERIOD/2) clk = ~clk;

   logic [W-1:0] w0, w1, w2, w3;
   logic [2:0]   box;
   logic         inv;
   logic [W-1:0] z0, z1, z2, z3;

   sbx_bitslice_unit #(.WORD_W(W)) i_sbx_bitslice_unit (
      .w0_i(w0), .w1_i(w1), .w2_i(w2), .w3_i(w3),
      .box_i(box), .inverse_i(inv),
      .z0_o(z0), .z1_o(z1), .z2_o(z2), .z3_o(z3)
   );

   int  n_checks = 0;
   int  n_errors = 0;
   bit  finished = 1'b0;

   // Reference boxes as given in R2 and R3.
   int fwd_tab [8][16] = '{
      '{3,8,15,1,10,6,5,11,14,13,4,2,7,0,9,12},
      '{15,12,2,7,9,0,5,10,1,11,14,8,6,13,3,4},
      '{8,6,7,9,3,12,10,15,13,1,14,4,0,11,5,2},
      '{0,15,11,8,12,9,6,3,13,1,2,4,10,7,5,14},
      '{1,15,8,3,12,0,11,6,2,5,4,10,9,14,7,13},
      '{15,5,2,11,4,10,9,12,0,3,14,8,13,6,7,1},
      '{7,2,12,5,8,4,6,11,14,9,1,15,13,3,10,0},
      '{1,13,15,0,14,8,2,11,7,4,12,10,9,3,5,6}};

   function automatic int ref_box(int b, bit d, int v);
      if (!d) return fwd_tab[b][v];
      for (int u = 0; u < 16; u++) if (fwd_tab[b][u] == v) return u;
      return -1;
   endfunction

   task automatic drive(input logic [W-1:0] a0, a1, a2, a3, input int b, input bit d);
      w0 = a0; w1 = a1; w2 = a2; w3 = a3; box = 3'(b); inv = d;
      #1;
   endtask

   // Compare all four output words with the per-position reference (R1 ordering).
   task automatic check_words(input string req, input int b, input bit d);
      logic [W-1:0] e0, e1, e2, e3;
      for (int i = 0; i < W; i++) begin
         int v, r;
         v = {w3[i], w2[i], w1[i], w0[i]};
         r = ref_box(b, d, v);
         e0[i] = r[0]; e1[i] = r[1]; e2[i] = r[2]; e3[i] = r[3];
      end
      n_checks++;
      if ({z3, z2, z1, z0} !== {e3, e2, e1, e0}) begin
         n_errors++;
         $display("FAIL %s box=%0d inv=%0d actual=%h_%h_%h_%h expected=%h_%h_%h_%h",
                  req, b, d, z3, z2, z1, z0, e3, e2, e1, e0);
      end
   endtask

   logic [W-1:0] rp0, rp1, rp2, rp3, mx0, mx1, mx2, mx3;

   initial begin
      for (int i = 0; i < W; i++) begin
         rp0[i] = i[0]; rp1[i] = i[1]; rp2[i] = i[2]; rp3[i] = i[3];
      end
      mx0 = 32'h9E37_79B9; mx1 = 32'h7F4A_7C15; mx2 = 32'hC2B2_AE35; mx3 = 32'h1656_67B1;
      for (int s = 0; s < 3; s++) begin
         mx0 = mx0 ^ (mx0 << 13); mx0 = mx0 ^ (mx0 >> 17); mx0 = mx0 ^ (mx0 << 5);
         mx1 = mx1 ^ (mx1 << 7);  mx1 = mx1 ^ (mx1 >> 9);
         mx2 = mx2 ^ (mx2 >> 11); mx3 = mx3 ^ (mx3 << 3) ^ mx0;
      end
      drive('0, '0, '0, '0, 0, 1'b0);

      // R2, R3, R1, R6: ramp, reversed ramp and scrambled patterns, all boxes, forward.
      for (int b = 0; b < 8; b++) begin
         drive(rp0, rp1, rp2, rp3, b, 1'b0);     check_words(b < 4 ? "R2" : "R3", b, 1'b0);
         drive(~rp0, ~rp1, ~rp2, ~rp3, b, 1'b0); check_words("R1", b, 1'b0);
         drive(mx0, mx1, mx2, mx3, b, 1'b0);     check_words("R6", b, 1'b0);
      end
      // R4: inverse boxes on the same patterns.
      for (int b = 0; b < 8; b++) begin
         drive(rp0, rp1, rp2, rp3, b, 1'b1); check_words("R4", b, 1'b1);
         drive(mx0, mx1, mx2, mx3, b, 1'b1); check_words("R4", b, 1'b1);
      end
      // R4: round trip forward then inverse returns the input.
      for (int b = 0; b < 8; b++) begin
         logic [W-1:0] f0, f1, f2, f3;
         drive(mx0, mx1, mx2, mx3, b, 1'b0);
         f0 = z0; f1 = z1; f2 = z2; f3 = z3;
         drive(f0, f1, f2, f3, b, 1'b1);
         n_checks++;
         if ({z3, z2, z1, z0} !== {mx3, mx2, mx1, mx0}) begin
            n_errors++;
            $display("FAIL R4 round trip box=%0d actual=%h_%h_%h_%h expected=%h_%h_%h_%h",
                     b, z3, z2, z1, z0, mx3, mx2, mx1, mx0);
         end
      end
      // R5: uniform words for every nibble value, box and direction.
      for (int d = 0; d < 2; d++) begin
         for (int b = 0; b < 8; b++) begin
            for (int v = 0; v < 16; v++) begin
               drive({W{v[0]}}, {W{v[1]}}, {W{v[2]}}, {W{v[3]}}, b, 1'(d));
               check_words("R5", b, 1'(d));
            end
         end
      end
      // R7: change box between clock edges; output follows with no edge.
      @(posedge clk); #2;
      drive(rp0, rp1, rp2, rp3, 2, 1'b0);
      box = 3'd6; #1;
      check_words("R7", 6, 1'b0);
      inv = 1'b1; #1;
      check_words("R7", 6, 1'b1);

      if (!finished) begin
         finished = 1'b1;
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         n_checks++;
         n_errors++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   end

endmodule